// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry

This block shapes the register form of an ALU's second operand. It takes a 32-bit register value, a shift kind, a shift amount and the incoming carry flag. It returns the shifted value and the carry-out that a flag-setting instruction would record. The shift kinds are no shift, logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right that passes through the carry flag.

Each shift kind has its own legal range of amounts. The two right shifts accept an amount of 32, but left shift and rotate stop at 31. When an amount falls outside the range for its kind, or the kind code is undefined, the block raises an illegal flag instead of producing a shifted value.

Results are captured in one register stage, so they appear one clock after the request. The source value is only read and is never written back anywhere.

Top module: `shf_operand2`

## Requirements
- R1: `out_valid` follows `in_valid` exactly one clock later, and the results for a request appear in that same cycle. While `rst` is high at a clock edge, `out_valid`, `out_result`, `out_carry` and `out_illegal` are cleared to 0.
- R2: The kind code is `in_kind`, with 0 = none, 1 = LSL, 2 = LSR, 3 = ASR, 4 = ROR, 5 = RRX, and 6 and 7 undefined. For kind 0, whatever the amount, and for LSL with amount 0, the result equals the operand and the carry-out equals `in_carry`.
- R3: LSL by n (1 to 31) shifts in zeros from the bottom. The carry-out is operand bit 32−n.
- R4: LSR by n (1 to 32) shifts in zeros from the top. The carry-out is operand bit n−1. For n = 32 the result is 0 and the carry-out is operand bit 31.
- R5: ASR by n (1 to 32) fills the vacated bits with operand bit 31. The carry-out is operand bit n−1. For n = 32 every result bit equals operand bit 31, and so does the carry-out.
- R6: ROR by n (1 to 31) rotates the operand right, and the carry-out equals result bit 31.
- R7: RRX ignores the amount. The result is `in_carry` placed above operand bits 31 down to 1, and the carry-out is operand bit 0.
- R8: The following cases set `out_illegal` to 1, with the result equal to the operand and the carry-out equal to `in_carry`: LSL with an amount of 32 or more, LSR or ASR with an amount of 0 or more than 32, ROR with an amount of 0 or 32 or more, and kinds 6 and 7. All other cases set `out_illegal` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 32 | Register value to shift |
| in_kind | input | 3 | Shift kind code |
| in_amt | input | 6 | Shift amount |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result strobe, one clock after the request |
| out_result | output | 32 | Shifted value |
| out_carry | output | 1 | Carry-out |
| out_illegal | output | 1 | Amount or kind outside the legal range |

## Verification
The directed vectors use walking-one and alternating operands at the ends of each kind's range (1, 31 and 32), so that a wrong carry-bit index or a wrong fill bit shows up as a single flipped bit. Operands with bit 31 set and operands with bit 31 clear separate arithmetic fill from logical fill. Both values of `in_carry` are applied to RRX, to the no-shift case and to the illegal cases, to show where carry passes through and where it is replaced. A random sweep over every kind and every 6-bit amount checks the illegal-range boundaries against an independent bit-by-bit model.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    SK_NONE = 3'd0,
    SK_LSL  = 3'd1,
    SK_LSR  = 3'd2,
    SK_ASR  = 3'd3,
    SK_ROR  = 3'd4,
    SK_RRX  = 3'd5
  } shift_kind_e;
endpackage

// File: rtl/shf_range_chk.sv
module shf_range_chk
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W) + 1
) (
  input  shift_kind_e        kind,
  input  logic [AMT_W-1:0]   amt,
  output logic               legal
);
  localparam logic [AMT_W-1:0] AMT_MAX = AMT_W'(W);

  always_comb begin
    unique case (kind)
      SK_NONE: legal = 1'b1;
      SK_RRX:  legal = 1'b1;
      SK_LSL:  legal = (amt < AMT_MAX);
      SK_LSR,
      SK_ASR:  legal = (amt != '0) && (amt <= AMT_MAX);
      SK_ROR:  legal = (amt != '0) && (amt < AMT_MAX);
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     op,
  input  shift_kind_e      kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam logic [AMT_W-1:0] AMT_W_VAL = AMT_W'(W);

  // Widened by one bit so the last bit shifted out is kept next to the result.
  logic [W:0]   ext_l;
  logic [W:0]   ext_r;
  logic [W:0]   ext_a;
  logic [W-1:0] rot;

  assign ext_l = {1'b0, op} << amt;
  assign ext_r = {op, 1'b0} >> amt;
  assign ext_a = $unsigned($signed({op, 1'b0}) >>> amt);
  assign rot   = (op >> amt) | (op << (AMT_W_VAL - amt));

  always_comb begin
    res  = op;
    cout = cin;
    unique case (kind)
      SK_LSL: if (amt != '0) begin
        res  = ext_l[W-1:0];
        cout = ext_l[W];
      end
      SK_LSR: begin
        res  = ext_r[W:1];
        cout = ext_r[0];
      end
      SK_ASR: begin
        res  = ext_a[W:1];
        cout = ext_a[0];
      end
      SK_ROR: begin
        res  = rot;
        cout = rot[W-1];
      end
      SK_RRX: begin
        res  = {cin, op[W-1:1]};
        cout = op[0];
      end
      default: begin
        res  = op;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/shf_operand2.sv
module shf_operand2
  import shf_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     in_operand,
  input  logic [2:0]       in_kind,
  input  logic [AMT_W-1:0] in_amt,
  input  logic             in_carry,
  output logic             out_valid,
  output logic [W-1:0]     out_result,
  output logic             out_carry,
  output logic             out_illegal
);
  shift_kind_e  kind_e;
  logic         legal;
  logic [W-1:0] sh_res;
  logic         sh_cout;

  assign kind_e = shift_kind_e'(in_kind);

  shf_range_chk #(.W(W), .AMT_W(AMT_W)) u_range (
    .kind  (kind_e),
    .amt   (in_amt),
    .legal (legal)
  );

  shf_barrel #(.W(W), .AMT_W(AMT_W)) u_barrel (
    .op   (in_operand),
    .kind (kind_e),
    .amt  (in_amt),
    .cin  (in_carry),
    .res  (sh_res),
    .cout (sh_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_carry   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_illegal <= ~legal;
        out_result  <= legal ? sh_res  : in_operand;
        out_carry   <= legal ? sh_cout : in_carry;
      end
    end
  end
endmodule

// File: rtl/shf_operand2_chk.sv
module shf_operand2_chk #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [W-1:0]     in_operand,
  input logic [2:0]       in_kind,
  input logic [AMT_W-1:0] in_amt,
  input logic             in_carry,
  input logic             out_valid,
  input logic [W-1:0]     out_result,
  input logic             out_carry,
  input logic             out_illegal
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_none_passes: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd0) |=>
      (out_result == $past(in_operand) && out_carry == $past(in_carry) && !out_illegal));
  a_r4_lsr_full: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd2 && in_amt == FULL) |=>
      (out_result == '0 && out_carry == $past(in_operand[W-1])));
  a_r6_ror_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd4 && !out_illegal) |=> (out_illegal || out_carry == out_result[W-1]));
  a_r7_rrx_through_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd5) |=>
      (out_carry == $past(in_operand[0]) && out_result[W-1] == $past(in_carry)));
  a_r8_bad_kind: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind[2:1] == 2'b11) |=> (out_illegal && out_result == $past(in_operand)));
endmodule

bind shf_operand2 shf_operand2_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
  .in_kind(in_kind), .in_amt(in_amt), .in_carry(in_carry),
  .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry),
  .out_illegal(out_illegal)
);

// File: tb/shf_operand2_tb.sv
`timescale 1ns/1ps
module shf_operand2_tb;
  localparam int W = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_operand = '0;
  logic [2:0]    in_kind = '0;
  logic [AW-1:0] in_amt = '0;
  logic          in_carry = 1'b0;
  logic          out_valid, out_carry, out_illegal;
  logic [W-1:0]  out_result;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    logic         ill;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  shf_operand2 #(.W(W), .AMT_W(AW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_kind(in_kind), .in_amt(in_amt), .in_carry(in_carry),
    .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry),
    .out_illegal(out_illegal)
  );

  // Bit-by-bit reference model written from the requirements.
  function automatic exp_t model(logic [W-1:0] op, logic [2:0] k, int n, logic c);
    exp_t e;
    e.res = op; e.cy = c; e.ill = 1'b0; e.tag = "R2";
    case (k)
      3'd0: e.tag = "R2";
      3'd1: if (n == 0) e.tag = "R2";
            else if (n < 32) begin
              for (int i = 0; i < W; i++) e.res[i] = (i >= n) ? op[i-n] : 1'b0;
              e.cy = op[32-n]; e.tag = "R3";
            end else e.ill = 1'b1;
      3'd2, 3'd3: if (n >= 1 && n <= 32) begin
              for (int i = 0; i < W; i++)
                e.res[i] = (i + n < W) ? op[i+n] : ((k == 3'd3) ? op[W-1] : 1'b0);
              e.cy = op[n-1]; e.tag = (k == 3'd2) ? "R4" : "R5";
            end else e.ill = 1'b1;
      3'd4: if (n >= 1 && n < 32) begin
              for (int i = 0; i < W; i++) e.res[i] = op[(i+n)%W];
              e.cy = e.res[W-1]; e.tag = "R6";
            end else e.ill = 1'b1;
      3'd5: begin
              for (int i = 0; i < W-1; i++) e.res[i] = op[i+1];
              e.res[W-1] = c; e.cy = op[0]; e.tag = "R7";
            end
      default: e.ill = 1'b1;
    endcase
    if (e.ill) begin e.res = op; e.cy = c; e.tag = "R8"; end
    return e;
  endfunction

  task automatic send(logic [W-1:0] op, logic [2:0] k, int n, logic c);
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_kind = k; in_amt = AW'(n); in_carry = c;
    sb.push_back(model(op, k, n, c));
  endtask

  // Monitor: pops one expected item per valid result.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R1 unexpected out_valid: actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (out_result !== e.res || out_carry !== e.cy || out_illegal !== e.ill) begin
          n_bad++;
          $display("FAIL %s actual res=%h cy=%b ill=%b expected res=%h cy=%b ill=%b",
                   e.tag, out_result, out_carry, out_illegal, e.res, e.cy, e.ill);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1; in_operand = 32'hFFFF_FFFF; in_carry = 1'b1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_result !== '0 || out_carry !== 1'b0 || out_illegal !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset state: actual v=%b r=%h c=%b i=%b expected all zero",
               out_valid, out_result, out_carry, out_illegal);
    end
    in_valid = 1'b0;
    rst = 1'b0;

    // R2: no shift, LSL #0
    send(32'hDEAD_BEEF, 3'd0, 0, 1'b1);
    send(32'h1234_5678, 3'd0, 17, 1'b0);
    send(32'h8000_0001, 3'd1, 0, 1'b1);
    // R3: LSL range ends
    send(32'h0000_0001, 3'd1, 1, 1'b0);
    send(32'h8000_0001, 3'd1, 1, 1'b0);
    send(32'h0000_0003, 3'd1, 31, 1'b1);
    // R4: LSR
    send(32'h8000_0001, 3'd2, 1, 1'b0);
    send(32'h8000_0000, 3'd2, 32, 1'b0);
    send(32'h7FFF_FFFF, 3'd2, 32, 1'b1);
    // R5: ASR
    send(32'h8000_0000, 3'd3, 31, 1'b0);
    send(32'h8000_0000, 3'd3, 32, 1'b0);
    send(32'h7FFF_FFFF, 3'd3, 32, 1'b1);
    // R6: ROR
    send(32'h0000_0001, 3'd4, 1, 1'b0);
    send(32'hA5A5_0F0F, 3'd4, 31, 1'b0);
    // R7: RRX, both carry values
    send(32'h0000_0001, 3'd7 - 3'd2, 40, 1'b1);
    send(32'hFFFF_FFFE, 3'd5, 0, 1'b0);
    // R8: illegal boundaries
    send(32'hCAFE_F00D, 3'd1, 32, 1'b1);
    send(32'hCAFE_F00D, 3'd2, 0, 1'b0);
    send(32'hCAFE_F00D, 3'd3, 33, 1'b1);
    send(32'hCAFE_F00D, 3'd4, 32, 1'b0);
    send(32'hCAFE_F00D, 3'd4, 0, 1'b1);
    send(32'hCAFE_F00D, 3'd6, 4, 1'b0);
    send(32'hCAFE_F00D, 3'd7, 4, 1'b1);
    // Random sweep across all kinds and amounts
    for (int j = 0; j < 400; j++)
      send($urandom, 3'($urandom % 8), int'($urandom % 64), 1'($urandom));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R1 results missing: actual=%0d pending expected=0", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule